// File: doc/BRIEF.md
# Reset stretcher with release logging

This block lengthens the warm reset that the chip sees after an external pad reset goes away. While the pad reset is held, the warm reset output is asserted. Once the pad reset lets go, the output stays asserted for a programmed number of slow-tick periods. The ticks come from a 32 kHz time base and arrive as one-cycle strobes in the fast clock domain.

Three sticky flags record which warm resets have ended:
- the stretched reset produced by this block,
- a reset from the application processor,
- a reset from the chip-to-chip link.

Each flag is set on the release of its reset, not on its assertion. Software clears a flag by writing one to it.

A second output drives an external power-on reset under software control. A separate arming bit guards it. The register port is a plain write strobe with an address and write data. Read data is combinational from the address.

Top module: `rst_stretch_log`

## Requirements
- R1: The stretch length register sits at address 0, bits [3:0]. It resets to 4 and reads back exactly the value written.
- R2: `warm_rst` is 1 in every cycle in which `pad_rst_n` is 0.
- R3: With an effective length L, `warm_rst` stays 1 after `pad_rst_n` returns high. It falls right after the clock edge that samples the L-th `tick_32k` strobe, and not before.
- R4: Stored length values 0, 1 and 2 give the same stretch as the value 3.
- R5: If `pad_rst_n` goes low again during a stretch, the count restarts, and a full L ticks are needed after the new release.
- R6: The status register sits at address 2. Bit 0 is set when `warm_rst` falls at the end of a stretch. Bit 1 is set when `ape_rst` falls. Bit 2 is set when `c2c_rst` falls. No bit is set by a rising reset.
- R7: Writing 1 to a status bit clears it. Writing 0 leaves it unchanged.
- R8: When a release event and a clearing write hit the same status bit in the same cycle, the bit ends up set.
- R9: The power-on control register sits at address 1. Bit 0 is the arming bit and bit 1 is the assert bit, and `ext_por` follows the assert bit. A write sets the assert bit only when the arming bit was already 1 before the write and the write also keeps bit 0 at 1.
- R10: A write that clears the arming bit also drops `ext_por`.
- R11: After `rst_n`, the status register is 0, the control register is 0, and `ext_por` and `warm_rst` are 0 while the pad reset is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low reset of the block's own registers |
| pad_rst_n | input | 1 | Active-low pad reset, synchronous to clk |
| tick_32k | input | 1 | One-cycle strobe per 32 kHz period |
| ape_rst | input | 1 | Application-processor warm reset level, active high |
| c2c_rst | input | 1 | Chip-to-chip link warm reset level, active high |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address for write and read |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for reg_addr |
| warm_rst | output | 1 | Stretched warm reset, active high |
| ext_por | output | 1 | Software-driven external power-on reset, active high |

## Verification
The assertions assume that `pad_rst_n`, `ape_rst` and `c2c_rst` are already synchronous to `clk`. They also assume that a low pad reset lasts at least one clock edge, so that the counter load is always seen.

The stimulus follows these assumptions:
- Every input changes on the falling clock edge.
- Pad pulses last one or more whole cycles.
- Tick strobes are exactly one cycle wide.

The release-flag and clear-collision cases are driven in the same cycle on purpose, to reach the set-over-clear priority.

// File: rtl/rst_stretch_log.sv
module rst_stretch_log #(
  parameter int LEN_W   = 4,
  parameter int MIN_LEN = 3,
  parameter int DEF_LEN = 4,
  parameter int DW      = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pad_rst_n,
  input  logic          tick_32k,
  input  logic          ape_rst,
  input  logic          c2c_rst,
  input  logic          reg_we,
  input  logic [1:0]    reg_addr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  output logic          warm_rst,
  output logic          ext_por
);
  localparam logic [1:0] A_LEN = 2'd0;
  localparam logic [1:0] A_POR = 2'd1;
  localparam logic [1:0] A_STS = 2'd2;
  localparam int NSRC = 3;

  logic [LEN_W-1:0] len_q, eff_len, cnt_q;
  logic             arm_q, por_q, ape_q, c2c_q;
  logic [NSRC-1:0]  sts_q, sts_set, sts_clr;
  logic             pad_act, we_len, we_por, we_sts, stretch_end;

  assign pad_act = !pad_rst_n;
  assign we_len  = reg_we && reg_addr == A_LEN;
  assign we_por  = reg_we && reg_addr == A_POR;
  assign we_sts  = reg_we && reg_addr == A_STS;
  assign eff_len = (len_q < LEN_W'(MIN_LEN)) ? LEN_W'(MIN_LEN) : len_q;

  assign stretch_end = !pad_act && tick_32k && cnt_q == LEN_W'(1);
  assign warm_rst    = pad_act || cnt_q != '0;
  assign ext_por     = por_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (pad_act) begin
      cnt_q <= eff_len;
    end else if (tick_32k && cnt_q != '0) begin
      cnt_q <= cnt_q - LEN_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      len_q <= LEN_W'(DEF_LEN);
      arm_q <= 1'b0;
      por_q <= 1'b0;
    end else begin
      if (we_len) len_q <= reg_wdata[LEN_W-1:0];
      if (we_por) begin
        arm_q <= reg_wdata[0];
        por_q <= reg_wdata[1] && reg_wdata[0] && arm_q;
      end
    end
  end

  assign sts_set = {c2c_q && !c2c_rst, ape_q && !ape_rst, stretch_end};
  assign sts_clr = we_sts ? reg_wdata[NSRC-1:0] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sts_q <= '0;
      ape_q <= 1'b0;
      c2c_q <= 1'b0;
    end else begin
      sts_q <= (sts_q & ~sts_clr) | sts_set;
      ape_q <= ape_rst;
      c2c_q <= c2c_rst;
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_LEN:   reg_rdata[LEN_W-1:0] = len_q;
      A_POR:   reg_rdata[1:0] = {por_q, arm_q};
      A_STS:   reg_rdata[NSRC-1:0] = sts_q;
      default: reg_rdata = '0;
    endcase
  end

  AST_HOLD_WHILE_PAD: assert property (@(posedge clk) disable iff (!rst_n)
    !pad_rst_n |=> warm_rst); // R2
  AST_NO_EARLY_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(warm_rst) |-> $past(tick_32k)); // R3
  AST_LEN_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pad_rst_n) |-> cnt_q >= LEN_W'(MIN_LEN)); // R4
  AST_RELEASE_LOGGED: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(warm_rst) |-> sts_q[0]); // R6
  AST_STICKY_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
    ((~sts_q & $past(sts_q)) != '0) |-> $past(we_sts)); // R7
  AST_POR_NEEDS_ARM: assert property (@(posedge clk) disable iff (!rst_n)
    ext_por |-> arm_q); // R9
endmodule

// File: tb/rst_stretch_log_tb.sv
module rst_stretch_log_tb;
  localparam int CLK_PER = 10;

  logic clk = 1'b0, rst_n = 1'b0, pad_rst_n = 1'b1, tick_32k = 1'b0;
  logic ape_rst = 1'b0, c2c_rst = 1'b0, reg_we = 1'b0;
  logic [1:0] reg_addr = 2'd0;
  logic [7:0] reg_wdata = 8'd0, reg_rdata;
  logic warm_rst, ext_por;
  int n_chk = 0, n_bad = 0;

  always #(CLK_PER/2) clk = ~clk;

  rst_stretch_log u_dut (.clk(clk), .rst_n(rst_n), .pad_rst_n(pad_rst_n),
    .tick_32k(tick_32k), .ape_rst(ape_rst), .c2c_rst(c2c_rst), .reg_we(reg_we),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .warm_rst(warm_rst), .ext_por(ext_por));

  task automatic check(string req, logic [7:0] got, logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [7:0] d);
    @(negedge clk); reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic rd(logic [1:0] a, output logic [7:0] d);
    reg_addr = a; #1; d = reg_rdata;
  endtask

  task automatic tick1();
    tick_32k = 1'b1; @(negedge clk); tick_32k = 1'b0;
  endtask

  task automatic pad_pulse(int n);
    pad_rst_n = 1'b0; #1;
    check("R2 warm_rst during pad", {7'd0, warm_rst}, 8'd1);
    repeat (n) @(negedge clk);
    pad_rst_n = 1'b1;
  endtask

  task automatic t_reset();
    logic [7:0] d;
    rd(2'd0, d); check("R1 len default", d, 8'd4);
    rd(2'd1, d); check("R11 ctrl reset", d, 8'd0);
    rd(2'd2, d); check("R11 status reset", d, 8'd0);
    check("R11 warm_rst idle", {7'd0, warm_rst}, 8'd0);
    check("R11 ext_por idle", {7'd0, ext_por}, 8'd0);
  endtask

  task automatic t_stretch(logic [3:0] len, int eff, string tag);
    logic [7:0] d;
    wr(2'd0, {4'd0, len});
    rd(2'd0, d); check("R1 len readback", d, {4'd0, len});
    pad_pulse(2);
    repeat (3) @(negedge clk);
    check({tag, " held without ticks"}, {7'd0, warm_rst}, 8'd1);
    for (int k = 0; k < eff - 1; k++) tick1();
    check({tag, " held before last tick"}, {7'd0, warm_rst}, 8'd1);
    tick1();
    check({tag, " released after last tick"}, {7'd0, warm_rst}, 8'd0);
    rd(2'd2, d); check("R6 stretch release logged", d, 8'd1);
    wr(2'd2, 8'd1);
    rd(2'd2, d); check("R7 clear by one", d, 8'd0);
  endtask

  task automatic t_restart();
    wr(2'd0, 8'd5);
    pad_pulse(1);
    repeat (3) tick1();
    pad_pulse(1);
    repeat (4) tick1();
    check("R5 held after restart", {7'd0, warm_rst}, 8'd1);
    tick1();
    check("R5 released after full count", {7'd0, warm_rst}, 8'd0);
    wr(2'd2, 8'd7);
  endtask

  task automatic t_sources();
    logic [7:0] d;
    @(negedge clk); ape_rst = 1'b1; c2c_rst = 1'b1;
    repeat (3) @(negedge clk);
    rd(2'd2, d); check("R6 no flag on assertion", d, 8'd0);
    ape_rst = 1'b0; @(negedge clk);
    rd(2'd2, d); check("R6 ape release flag", d, 8'd2);
    c2c_rst = 1'b0; @(negedge clk);
    rd(2'd2, d); check("R6 c2c release flag", d, 8'd6);
    wr(2'd2, 8'd0);
    rd(2'd2, d); check("R7 zero write ignored", d, 8'd6);
    wr(2'd2, 8'd2);
    rd(2'd2, d); check("R7 clear bit1 only", d, 8'd4);
    wr(2'd2, 8'd4);
    rd(2'd2, d); check("R7 clear bit2", d, 8'd0);
  endtask

  task automatic t_collide();
    logic [7:0] d;
    @(negedge clk); ape_rst = 1'b1;
    repeat (2) @(negedge clk);
    ape_rst = 1'b0; reg_we = 1'b1; reg_addr = 2'd2; reg_wdata = 8'd2;
    @(negedge clk); reg_we = 1'b0;
    rd(2'd2, d); check("R8 set wins over clear", d, 8'd2);
    wr(2'd2, 8'd2);
  endtask

  task automatic t_por();
    logic [7:0] d;
    wr(2'd1, 8'd2);
    check("R9 assert refused without arm", {7'd0, ext_por}, 8'd0);
    wr(2'd1, 8'd1);
    check("R9 arm alone no por", {7'd0, ext_por}, 8'd0);
    wr(2'd1, 8'd3);
    check("R9 armed assert", {7'd0, ext_por}, 8'd1);
    rd(2'd1, d); check("R9 ctrl readback", d, 8'd3);
    wr(2'd1, 8'd2);
    check("R10 disarm drops por", {7'd0, ext_por}, 8'd0);
    rd(2'd1, d); check("R10 ctrl after disarm", d, 8'd0);
  endtask

  initial begin
    #(CLK_PER * 100000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_stretch(4'd5, 5, "R3");
    t_stretch(4'd15, 15, "R3 max");
    t_stretch(4'd1, 3, "R4 len1");
    t_stretch(4'd0, 3, "R4 len0");
    t_stretch(4'd2, 3, "R4 len2");
    t_restart();
    t_sources();
    t_collide();
    t_por();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule